// File: doc/BRIEF.md
# Audio frame step sequencer

This block is the timing backbone of a retro console sound unit. It counts CPU-cycle enables and walks through a fixed schedule of steps whose lengths are not equal. On entering certain steps it sends out a one-clock pulse that clocks the channel length counters. In the interrupt mode it also raises a frame interrupt flag.

There are two schedules. Mode 0 has six steps and can raise an interrupt. Two of its steps last one cycle each, so the interrupt is set on three consecutive enabled cycles. Mode 1 has five steps and never raises an interrupt.

Software writes a control strobe that carries the mode and an interrupt-inhibit bit. The write restarts the schedule from its beginning. An acknowledge input, normally driven by a status read, clears the pending flag.

Top module: `frame_seq`

## Requirements
- R1: After reset the block is in mode 0 at step 0, with `irq` low and `len_clk` low.
- R2: In mode 0 the steps last 7456, 7458, 7457, 1, 1 and 7457 enabled cycles, in that order, and then wrap to step 0. The `step` output shows the current step index (0 to 5) one clock after the enabled edge that enters it.
- R3: In mode 0, `len_clk` is high for exactly one clock after the enabled edge that enters step 1 and after the enabled edge that enters step 4, and low at all other times.
- R4: In mode 0 with inhibit low, entering step 3, step 4 or step 5 sets the interrupt. `irq` goes high one clock after the edge that sets it and stays high until it is cleared.
- R5: In mode 1 the steps last 7458, 7456, 7458, 7456 and 7454 enabled cycles and then wrap. `step` stays within 0 to 4.
- R6: In mode 1, `len_clk` pulses for one clock after the edge that enters step 2 and after the edge that wraps into step 0. No interrupt is ever set in mode 1. The control write itself produces no pulse.
- R7: A control write (`wr` high) loads the mode from `wr_mode` (0 or 1) and returns the block to step 0 with the cycle count cleared. One clock later `step` is 0 and `len_clk` is low.
- R8: A control write with `wr_inh` = 1 clears `irq` on the next clock. While inhibit is held, `irq` stays low. A write with `wr_inh` = 0 leaves the current flag unchanged.
- R9: `ack` high clears `irq` on the next clock. When an interrupt set is due on that same clock, the set wins and `irq` stays high.
- R10: The cycle count and the step advance only on clocks where `ce` is high. On a clock with `ce` low, `step` holds and `len_clk` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ce | input | 1 | CPU-cycle enable; the schedule advances one count per high clock |
| wr | input | 1 | Control write strobe |
| wr_mode | input | 1 | Mode selected by the write: 0 for six steps with interrupt, 1 for five steps |
| wr_inh | input | 1 | Interrupt inhibit loaded by the write |
| ack | input | 1 | Interrupt acknowledge; clears the flag |
| len_clk | output | 1 | One-clock length-counter clock pulse |
| irq | output | 1 | Frame interrupt flag |
| step | output | 3 | Current step index |

## Verification
Mode 0 is run for two full periods with `ce` held high. Every clock's step index, pulse and flag is compared against boundaries computed from the step lengths. This separates the unequal step lengths, and it shows whether the flag stays high across the three back-to-back sets and comes back after a wrap.

Two acknowledges are placed in the mode 0 run. One coincides with the last set and the other comes later, which tells "set wins" apart from a plain clear. An inhibit write is then made while the flag is high, and the run continues long enough that a set would otherwise have been due.

Mode 1 is run for two full periods to check its own boundaries, the pulse on the wrap into step 0, and the absence of any interrupt. A final mode 0 run holds `ce` low on every fourth clock. This confirms that only enabled clocks are counted and that the pulse still lasts a single clock.

// File: rtl/frame_seq.sv
module frame_seq #(
  parameter int M0_S0 = 7456,
  parameter int M0_S1 = 7458,
  parameter int M0_S2 = 7457,
  parameter int M0_S3 = 1,
  parameter int M0_S4 = 1,
  parameter int M0_S5 = 7457,
  parameter int M1_S0 = 7458,
  parameter int M1_S1 = 7456,
  parameter int M1_S2 = 7458,
  parameter int M1_S3 = 7456,
  parameter int M1_S4 = 7454
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ce,
  input  logic       wr,
  input  logic       wr_mode,
  input  logic       wr_inh,
  input  logic       ack,
  output logic       len_clk,
  output logic       irq,
  output logic [2:0] step
);

  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int MAXD = mx(mx(mx(mx(M0_S0, M0_S1), mx(M0_S2, M0_S3)), mx(M0_S4, M0_S5)),
                           mx(mx(mx(M1_S0, M1_S1), mx(M1_S2, M1_S3)), M1_S4));
  localparam int CW = $clog2(MAXD) + 1;

  logic          mode_q, inh_q, set_q, len_q, irq_q;
  logic [2:0]    step_q, nxt;
  logic [CW-1:0] cyc_q, last_v;
  logic          last, adv, len_hit, irq_hit;

  always_comb begin
    last_v = '0;
    if (!mode_q) begin
      case (step_q)
        3'd0:    last_v = CW'(M0_S0 - 1);
        3'd1:    last_v = CW'(M0_S1 - 1);
        3'd2:    last_v = CW'(M0_S2 - 1);
        3'd3:    last_v = CW'(M0_S3 - 1);
        3'd4:    last_v = CW'(M0_S4 - 1);
        default: last_v = CW'(M0_S5 - 1);
      endcase
    end else begin
      case (step_q)
        3'd0:    last_v = CW'(M1_S0 - 1);
        3'd1:    last_v = CW'(M1_S1 - 1);
        3'd2:    last_v = CW'(M1_S2 - 1);
        3'd3:    last_v = CW'(M1_S3 - 1);
        default: last_v = CW'(M1_S4 - 1);
      endcase
    end
  end

  assign last    = (cyc_q == last_v);
  assign adv     = ce && last;
  assign nxt     = (step_q == (mode_q ? 3'd4 : 3'd5)) ? 3'd0 : step_q + 3'd1;
  assign len_hit = mode_q ? (nxt == 3'd0 || nxt == 3'd2) : (nxt == 3'd1 || nxt == 3'd4);
  assign irq_hit = !mode_q && !inh_q && (nxt >= 3'd3);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= 1'b0;
      inh_q  <= 1'b0;
      step_q <= '0;
      cyc_q  <= '0;
      len_q  <= 1'b0;
      set_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else if (wr) begin
      mode_q <= wr_mode;
      inh_q  <= wr_inh;
      step_q <= '0;
      cyc_q  <= '0;
      len_q  <= 1'b0;
      set_q  <= 1'b0;
      if (wr_inh) irq_q <= 1'b0;
    end else begin
      len_q <= adv && len_hit;
      set_q <= adv && irq_hit;
      if (ce) begin
        if (last) begin
          step_q <= nxt;
          cyc_q  <= '0;
        end else begin
          cyc_q <= cyc_q + 1'b1;
        end
      end
      if (inh_q)      irq_q <= 1'b0;
      else if (set_q) irq_q <= 1'b1;
      else if (ack)   irq_q <= 1'b0;
    end
  end

  assign len_clk = len_q;
  assign irq     = irq_q;
  assign step    = step_q;

endmodule

module frame_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       ce,
  input logic       wr,
  input logic       ack,
  input logic       len_clk,
  input logic       irq,
  input logic [2:0] step,
  input logic       mode_q,
  input logic       inh_q,
  input logic       set_q
);

  p_len_single_r3: assert property (@(posedge clk) disable iff (rst)
    len_clk |=> !len_clk);

  p_step_range_r2: assert property (@(posedge clk) disable iff (rst)
    !mode_q |-> step <= 3'd5);

  p_step_range_r5: assert property (@(posedge clk) disable iff (rst)
    mode_q |-> step <= 3'd4);

  p_no_set_mode1_r6: assert property (@(posedge clk) disable iff (rst)
    mode_q |-> !set_q);

  p_wr_restart_r7: assert property (@(posedge clk) disable iff (rst)
    wr |=> (step == 3'd0 && !len_clk));

  p_inh_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    inh_q |-> !irq);

  p_ack_clear_r9: assert property (@(posedge clk) disable iff (rst)
    (ack && !set_q && !wr) |=> !irq);

  p_ce_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (!ce && !wr) |=> ($stable(step) && !len_clk));

endmodule

bind frame_seq frame_seq_chk u_chk (
  .clk(clk), .rst(rst), .ce(ce), .wr(wr), .ack(ack),
  .len_clk(len_clk), .irq(irq), .step(step),
  .mode_q(mode_q), .inh_q(inh_q), .set_q(set_q)
);

// File: tb/test_frame_seq.sv
`timescale 1ns/1ps
module test_frame_seq;
  logic clk = 1'b0;
  logic rst, ce, wr, wr_mode, wr_inh, ack;
  logic len_clk, irq;
  logic [2:0] step;

  always #2 clk = ~clk;

  frame_seq i_frame_seq (
    .clk(clk), .rst(rst), .ce(ce), .wr(wr), .wr_mode(wr_mode), .wr_inh(wr_inh),
    .ack(ack), .len_clk(len_clk), .irq(irq), .step(step)
  );

  int total = 0;
  int bad = 0;
  int n = 0;
  bit mode_m = 0, inh_m = 0, irq_m = 0, set_m = 0;
  string tag_s = "R2", tag_l = "R3", tag_i = "R4";

  function automatic int dur(input bit m, input int s);
    if (!m) begin
      case (s)
        0: return 7456; 1: return 7458; 2: return 7457;
        3: return 1;    4: return 1;    default: return 7457;
      endcase
    end else begin
      case (s)
        0: return 7458; 1: return 7456; 2: return 7458;
        3: return 7456; default: return 7454;
      endcase
    end
  endfunction

  function automatic int bnd(input bit m, input int s);
    int acc = 0;
    for (int k = 0; k < s; k++) acc += dur(m, k);
    return acc;
  endfunction

  function automatic int period(input bit m);
    return bnd(m, m ? 5 : 6);
  endfunction

  function automatic int step_of(input bit m, input int p);
    int r = 0;
    for (int s = 0; s < (m ? 5 : 6); s++) if (p >= bnd(m, s)) r = s;
    return r;
  endfunction

  function automatic bit is_len(input bit m, input int p);
    if (m) return (p == 0) || (p == bnd(1, 2));
    return (p == bnd(0, 1)) || (p == bnd(0, 4));
  endfunction

  function automatic bit is_set(input bit m, input int p);
    return !m && (p == bnd(0, 3) || p == bnd(0, 4) || p == bnd(0, 5));
  endfunction

  task automatic chk(input string r, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d n=%0d t=%0t", r, act, exp, n, $time);
    end
  endtask

  task automatic cyc(input bit c, input bit a);
    int p;
    bit len_e;
    ce = c; ack = a;
    @(posedge clk);
    if (c) n++;
    p = n % period(mode_m);
    irq_m = inh_m ? 1'b0 : set_m ? 1'b1 : a ? 1'b0 : irq_m;
    set_m = c && !inh_m && is_set(mode_m, p);
    len_e = c && is_len(mode_m, p);
    @(negedge clk);
    ack = 1'b0;
    chk(tag_s, int'(step), step_of(mode_m, p));
    chk(tag_l, int'(len_clk), int'(len_e));
    chk(tag_i, int'(irq), int'(irq_m));
  endtask

  task automatic wr_ctl(input bit m, input bit i);
    wr = 1'b1; wr_mode = m; wr_inh = i; ce = 1'b1;
    @(posedge clk);
    n = 0; mode_m = m; inh_m = i; set_m = 0;
    if (i) irq_m = 0;
    @(negedge clk);
    wr = 1'b0;
    chk("R7", int'(step), 0);
    chk("R7", int'(len_clk), 0);
    chk(i ? "R8" : "R7", int'(irq), int'(irq_m));
  endtask

  initial begin
    rst = 1'b1; ce = 1'b0; wr = 1'b0; wr_mode = 1'b0; wr_inh = 1'b0; ack = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R1", int'(step), 0);
    chk("R1", int'(irq), 0);
    chk("R1", int'(len_clk), 0);

    // mode 0, two periods, ack coinciding with a set and later on its own
    wr_ctl(0, 0);
    tag_s = "R2"; tag_l = "R3"; tag_i = "R4";
    for (int k = 1; k <= 2 * 29830; k++) begin
      cyc(1, k == 22374 || k == 25000);
      if (k == 22372) chk("R4", int'(irq), 1);
      if (k == 22374) chk("R9", int'(irq), 1);
      if (k == 25000) chk("R9", int'(irq), 0);
    end

    // inhibit while flag is high
    chk("R4", int'(irq), 1);
    wr_ctl(0, 1);
    chk("R8", int'(irq), 0);
    tag_i = "R8";
    for (int k = 1; k <= 22400; k++) cyc(1, 0);
    chk("R8", int'(irq), 0);

    // mode 1, two periods
    wr_ctl(1, 0);
    chk("R6", int'(len_clk), 0);
    tag_s = "R5"; tag_l = "R6"; tag_i = "R6";
    for (int k = 1; k <= 2 * 37282; k++) cyc(1, 0);
    chk("R6", int'(irq), 0);

    // mode 0 with gaps in the enable
    wr_ctl(0, 0);
    tag_s = "R10"; tag_l = "R10"; tag_i = "R10";
    for (int k = 0; n < 7460; k++) cyc(k % 4 != 3, 0);
    chk("R10", int'(step), 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 199000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule